// File: doc/BRIEF.md
# PCIe Traffic Generator Control Engine

This block sits behind a 32-bit register slave in a PCIe endpoint and turns host configuration into a stream of write or read request descriptors. Software programs a 64-bit target address, a length in dwords, a data pattern and a request count. It then rings a doorbell in the control register. The engine presents one descriptor at a time on a valid/ready output until the programmed count has been accepted. It then raises a done flag in the status register.

A repeat flag in the burst-count register makes the engine restart the burst each time the count runs out. Each new burst starts again at the programmed base address. Clearing the flag while traffic runs stops the engine once the descriptor currently on offer has been accepted. Two options shape the stream. With address stepping disabled, every descriptor targets the same address. With pattern stepping enabled, the data pattern runs on from one descriptor to the next.

Two 64-bit byte counters, one for accepted write traffic and one for returned read completions, support throughput measurement. A single enable bit gates both counters. Software clears that bit to freeze them, reads each counter as two 32-bit halves, and then sets the bit again.

Top module: `pcie_trafgen_ctrl`

## Requirements
- R1: After reset every register reads 0 and `req_valid` is low.
- R2: Writing the control word (offset 0x00C) with bit 0 set while idle starts a run. Each descriptor carries `req_write` = control bit 1 and `req_len` = control bits 13:2. The first descriptor's address is {0x004, 0x000} and its pattern is the value at offset 0x010. A run without repeat issues exactly burst-count bits 30:0 (offset 0x008) descriptors. Status (offset 0x014) then reads 1: bit 0 is done, bit 1 is busy.
- R3: When control bit 18 is 0, each accepted descriptor moves the next address up by len×4 bytes. When bit 18 is 1, every descriptor uses the same address. In repeat mode, each new burst starts again at the base address.
- R4: When control bit 16 is 1, each descriptor's pattern is the previous pattern plus len. When bit 16 is 0, the pattern stays the same.
- R5: With burst-count bit 31 set at the doorbell, bursts repeat without end. If software clears bit 31 during the run, the next accepted descriptor is the last one, and done is then set.
- R6: Any write to the control word while a run is active is ignored: its doorbell, direction, length and option bits have no effect.
- R7: A descriptor on offer stays valid, and its fields stay unchanged, until `req_ready` accepts it.
- R8: Writing status with bit 0 = 0 clears done. A doorbell with a request count of zero sets done at once and issues no descriptor.
- R9: Performance control bit 5 (offset 0x058) enables the counters. The write counter (0x100 low, 0x104 high) adds len×4 for each accepted write descriptor. The read counter (0x108 low, 0x10C high) adds 4 for each `cpl_valid` beat. Both counters hold while bit 5 is 0.
- R10: Every other offset, including 0x018 and 0x01C, reads 0, and writes to it are ignored.
- R11: Address low/high, burst count, pattern and performance control read back as written. Control reads back its stored fields, and bit 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset, shared by reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| req_valid | output | 1 | Descriptor on offer |
| req_ready | input | 1 | Downstream accepts the descriptor |
| req_write | output | 1 | 1 for a write descriptor, 0 for a read |
| req_addr | output | 64 | Target byte address |
| req_len | output | 12 | Length in dwords |
| req_pattern | output | 32 | Data pattern of the first dword |
| cpl_valid | input | 1 | One read-completion dword returned |

## Verification
The bench goes after four corner cases.

- Burst rollover in repeat mode. A design that carried the address on past the burst end, rather than returning to the base, would show wrong addresses from the fourth descriptor onward.
- Stopping in the middle of a burst. A design that waited for the burst to finish would issue extra descriptors after the stop.
- Doorbell while busy. A design that let a second doorbell through would alter the length or restart the count.
- Counter freeze and zero-count start. A design that kept counting while disabled would change the counter values, and a zero-count start that never finished would never raise done.

// File: rtl/pcie_trafgen_ctrl.sv
module pcie_trafgen_ctrl #(
  parameter int REG_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [63:0]       req_addr,
  output logic [11:0]       req_len,
  output logic [31:0]       req_pattern,
  input  logic              cpl_valid
);
  localparam logic [REG_AW-1:0] OFF_ALO   = REG_AW'('h000);
  localparam logic [REG_AW-1:0] OFF_AHI   = REG_AW'('h004);
  localparam logic [REG_AW-1:0] OFF_BURST = REG_AW'('h008);
  localparam logic [REG_AW-1:0] OFF_CTRL  = REG_AW'('h00C);
  localparam logic [REG_AW-1:0] OFF_PAT   = REG_AW'('h010);
  localparam logic [REG_AW-1:0] OFF_STAT  = REG_AW'('h014);
  localparam logic [REG_AW-1:0] OFF_PERF  = REG_AW'('h058);
  localparam logic [REG_AW-1:0] OFF_WCL   = REG_AW'('h100);
  localparam logic [REG_AW-1:0] OFF_WCH   = REG_AW'('h104);
  localparam logic [REG_AW-1:0] OFF_RCL   = REG_AW'('h108);
  localparam logic [REG_AW-1:0] OFF_RCH   = REG_AW'('h10C);

  logic [31:0] addr_lo, addr_hi, burst, pattern, cur_pat;
  logic [11:0] len;
  logic        dir_wr, pat_inc, no_ainc;
  logic        busy, done, rep_lat, perf_en;
  logic [30:0] remain;
  logic [63:0] cur_addr, wr_cnt, rd_cnt;

  wire [63:0] base   = {addr_hi, addr_lo};
  wire [63:0] step   = {50'd0, len, 2'b00};
  wire        fire   = busy & req_ready;
  wire        go     = reg_wr && reg_addr == OFF_CTRL && reg_wdata[0] && !busy;
  wire        last   = remain == 31'd1;
  wire        cnt_z  = burst[30:0] == 31'd0;
  wire        stop   = fire && ((rep_lat && !burst[31]) || (last && (!rep_lat || cnt_z)));
  wire        reload = fire && last && rep_lat && burst[31] && !cnt_z;

  assign req_valid   = busy;
  assign req_write   = dir_wr;
  assign req_addr    = cur_addr;
  assign req_len     = len;
  assign req_pattern = cur_pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0; addr_hi <= '0; burst <= '0; pattern <= '0; cur_pat <= '0;
      len <= '0; dir_wr <= 1'b0; pat_inc <= 1'b0; no_ainc <= 1'b0;
      busy <= 1'b0; done <= 1'b0; rep_lat <= 1'b0; perf_en <= 1'b0;
      remain <= '0; cur_addr <= '0; wr_cnt <= '0; rd_cnt <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFF_ALO:   addr_lo <= reg_wdata;
          OFF_AHI:   addr_hi <= reg_wdata;
          OFF_BURST: burst   <= reg_wdata;
          OFF_PAT:   pattern <= reg_wdata;
          OFF_STAT:  if (!reg_wdata[0]) done <= 1'b0;
          OFF_PERF:  perf_en <= reg_wdata[5];
          OFF_CTRL:  if (!busy) begin
                       dir_wr  <= reg_wdata[1];
                       len     <= reg_wdata[13:2];
                       pat_inc <= reg_wdata[16];
                       no_ainc <= reg_wdata[18];
                     end
          default: ;
        endcase
      end
      if (go) begin
        if (cnt_z) done <= 1'b1;
        else       busy <= 1'b1;
        remain   <= burst[30:0];
        rep_lat  <= burst[31];
        cur_addr <= base;
        cur_pat  <= pattern;
      end
      if (fire) begin
        if (stop) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (reload) begin
          remain   <= burst[30:0];
          cur_addr <= base;
        end else begin
          remain <= remain - 31'd1;
          if (!no_ainc) cur_addr <= cur_addr + step;
        end
        if (pat_inc) cur_pat <= cur_pat + {20'd0, len};
      end
      if (perf_en) begin
        if (fire && dir_wr) wr_cnt <= wr_cnt + step;
        if (cpl_valid)      rd_cnt <= rd_cnt + 64'd4;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_ALO:   reg_rdata = addr_lo;
      OFF_AHI:   reg_rdata = addr_hi;
      OFF_BURST: reg_rdata = burst;
      OFF_CTRL:  reg_rdata = {13'd0, no_ainc, 1'b0, pat_inc, 2'b00, len, dir_wr, 1'b0};
      OFF_PAT:   reg_rdata = pattern;
      OFF_STAT:  reg_rdata = {30'd0, busy, done};
      OFF_PERF:  reg_rdata = {26'd0, perf_en, 5'd0};
      OFF_WCL:   reg_rdata = wr_cnt[31:0];
      OFF_WCH:   reg_rdata = wr_cnt[63:32];
      OFF_RCL:   reg_rdata = rd_cnt[31:0];
      OFF_RCH:   reg_rdata = rd_cnt[63:32];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcie_trafgen_ctrl_chk.sv
module pcie_trafgen_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [63:0] req_addr,
  input logic [31:0] req_pattern,
  input logic        no_ainc,
  input logic        busy,
  input logic        done,
  input logic        perf_en,
  input logic [63:0] wr_cnt,
  input logic [63:0] rd_cnt
);
  p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_pattern) && $stable(req_write));

  p_fixed_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && no_ainc |=> !req_valid || $stable(req_addr));

  p_end_sets_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_frozen_counters_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !perf_en |=> $stable(wr_cnt) && $stable(rd_cnt));

  p_wr_cnt_only_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(wr_cnt));
endmodule

bind pcie_trafgen_ctrl pcie_trafgen_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_pattern(req_pattern),
  .no_ainc(no_ainc), .busy(busy), .done(done), .perf_en(perf_en),
  .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
);

// File: tb/pcie_trafgen_ctrl_bench.sv
module pcie_trafgen_ctrl_bench;
  localparam int CLK_P = 10;
  localparam logic [63:0] B = 64'h0000_0001_0000_1000;

  logic clk = 0, rst_n = 0, reg_wr = 0, req_ready = 0, cpl_valid = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, req_pattern;
  logic req_valid, req_write;
  logic [63:0] req_addr;
  logic [11:0] req_len;
  int checks = 0, failures = 0;

  typedef struct packed { logic w; logic [63:0] a; logic [11:0] l; logic [31:0] p; } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  pcie_trafgen_ctrl u_pcie_trafgen_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_pattern(req_pattern), .cpl_valid(cpl_valid));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1 reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1 reg_addr = a; #2 d = reg_rdata;
  endtask

  task automatic rchk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic push(logic w, logic [63:0] a, logic [11:0] l, logic [31:0] p);
    exp_t e;
    e.w = w; e.a = a; e.l = l; e.p = p;
    q.push_back(e);
  endtask

  task automatic accept(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 req_ready = 1;
      do @(negedge clk); while (!req_valid);
      @(posedge clk); #1 req_ready = 0;
    end
  endtask

  task automatic cpl(int n);
    @(posedge clk); #1 cpl_valid = 1;
    repeat (n) @(posedge clk);
    #1 cpl_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected descriptor actual=%h expected=none", req_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R2 write", {63'd0, req_write}, {63'd0, e.w});
        chk("R2 len", {52'd0, req_len}, {52'd0, e.l});
        chk("R3 addr", req_addr, e.a);
        chk("R4 pattern", {32'd0, req_pattern}, {32'd0, e.p});
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rchk("R1 addr_lo", 12'h000, 0);
    rchk("R1 burst", 12'h008, 0);
    rchk("R1 ctrl", 12'h00C, 0);
    rchk("R1 status", 12'h014, 0);
    rchk("R1 wcnt", 12'h100, 0);
    chk("R1 req_valid", {63'd0, req_valid}, 0);

    // R11 readback
    wr(12'h000, 32'h0000_1000);
    wr(12'h004, 32'h0000_0001);
    wr(12'h010, 32'h0000_0100);
    wr(12'h058, 32'h20);
    rchk("R11 addr_lo", 12'h000, 32'h1000);
    rchk("R11 addr_hi", 12'h004, 32'h1);
    rchk("R11 pattern", 12'h010, 32'h100);
    rchk("R11 perf", 12'h058, 32'h20);

    // R2 R3 R4 R7 R9: 3 writes, stepping address and pattern
    wr(12'h008, 3);
    push(1, B, 4, 32'h100); push(1, B + 16, 4, 32'h104); push(1, B + 32, 4, 32'h108);
    wr(12'h00C, 32'h0001_0013);
    rchk("R11 ctrl", 12'h00C, 32'h0001_0012);
    repeat (3) @(posedge clk);
    #2 chk("R7 held valid", {63'd0, req_valid}, 1);
    chk("R7 held addr", req_addr, B);
    accept(3);
    rchk("R2 done", 12'h014, 1);
    rchk("R9 wcnt lo", 12'h100, 48);
    rchk("R9 wcnt hi", 12'h104, 0);
    chk("R2 queue drained", q.size(), 0);

    // R8 status clear
    wr(12'h014, 0);
    rchk("R8 cleared", 12'h014, 0);

    // R3 fixed address, R4 fixed pattern, read dir, R6 doorbell while busy
    wr(12'h008, 2);
    push(0, B, 4, 32'h100); push(0, B, 4, 32'h100);
    wr(12'h00C, 32'h0004_0011);
    wr(12'h00C, 32'h0000_001F);
    rchk("R6 ctrl unchanged", 12'h00C, 32'h0004_0010);
    rchk("R6 still busy", 12'h014, 2);
    accept(2);
    rchk("R6 done after 2", 12'h014, 1);
    rchk("R9 wcnt read dir", 12'h100, 48);
    chk("R6 queue drained", q.size(), 0);

    // R9 completions and freeze
    cpl(3);
    rchk("R9 rcnt", 12'h108, 12);
    wr(12'h058, 0);
    cpl(2);
    rchk("R9 rcnt frozen", 12'h108, 12);
    wr(12'h014, 0);
    wr(12'h008, 1);
    push(1, B, 4, 32'h100);
    wr(12'h00C, 32'h0001_0013);
    accept(1);
    rchk("R9 wcnt frozen", 12'h100, 48);
    rchk("R9 wcnt hi frozen", 12'h104, 0);

    // R8 zero count
    wr(12'h014, 0);
    wr(12'h008, 0);
    wr(12'h00C, 32'h13);
    repeat (2) @(posedge clk);
    rchk("R8 zero count done", 12'h014, 1);
    chk("R8 no request", {63'd0, req_valid}, 0);

    // R5 repeat and stop mid-burst
    wr(12'h014, 0);
    wr(12'h008, 32'h8000_0003);
    push(1, B, 4, 32'h100); push(1, B + 16, 4, 32'h100); push(1, B + 32, 4, 32'h100);
    push(1, B, 4, 32'h100); push(1, B + 16, 4, 32'h100);
    wr(12'h00C, 32'h13);
    accept(4);
    wr(12'h008, 3);
    rchk("R5 running", 12'h014, 2);
    accept(1);
    rchk("R5 stopped done", 12'h014, 1);
    chk("R5 no request", {63'd0, req_valid}, 0);
    chk("R5 queue drained", q.size(), 0);

    // R10 unmapped
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    rchk("R10 ram addr", 12'h018, 0);
    rchk("R10 ram port", 12'h01C, 0);
    rchk("R10 reserved", 12'h020, 0);
    rchk("R10 others kept", 12'h000, 32'h1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule